// File: doc/BRIEF.md
# Display Controller Command Decoder and Register Bank

This block sits behind a serial slave port. Each byte it receives is tagged as either an opcode or a parameter. An opcode byte selects a command. The parameter bytes that follow it are placed, one by one, into that command's configuration fields. When a configuration field has not yet been written, it holds its default value. Opcodes that start work (power up, power down, screen refresh, deep sleep) raise a one-cycle action pulse, and they also drop the busy flag. The busy flag stays low until the downstream sequencer signals completion on `act_done`. While the flag is low, every incoming byte is discarded.

Two opcodes are readable. The status opcode takes a snapshot of a packed flag byte that combines external subsystem flags with the block's own power and busy state. The revision opcode returns a fixed identifier. The read-back byte follows the most recent opcode and appears one cycle after that opcode is accepted.

Top module: `cmdbank_top`

## Requirements
- R1: While `rst_n` is low, and after it returns high, the outputs hold these values: `cfg_panel`=07h, `cfg_boost_a`=03h, `cfg_boost_b`=00h, `cfg_boost_c`=26h, `cfg_hres`=0, `cfg_vres`=0, `busy_n`=1, `rd_byte`=00h, and no pulse is active.
- R2: Opcode 00h takes one parameter. The first parameter byte is copied to `cfg_panel`.
- R3: Opcode 06h takes three parameters. They go to `cfg_boost_a`, then `cfg_boost_b`, then `cfg_boost_c`. Only bits [5:0] of the third parameter are kept.
- R4: Opcode 61h takes four parameters. Bit 0 of byte 1 becomes `cfg_hres[8]`. Bits [7:1] of byte 2 become `cfg_hres[7:1]`, and `cfg_hres[0]` is forced to 0. Bit 0 of byte 3 becomes `cfg_vres[8]`. Byte 4 becomes `cfg_vres[7:0]`.
- R5: Parameters beyond an opcode's count change nothing. Each opcode byte restarts the parameter count at zero, and an opcode byte on its own changes no configuration field.
- R6: An opcode with no defined meaning, and any parameters that follow it, change no configuration field.
- R7: Opcodes 02h (power down), 04h (power up), 11h (data stop) and 12h (refresh) each raise their own pulse for exactly one cycle, starting the cycle after the opcode is accepted. Opcodes 02h, 04h and 12h also drive `busy_n` low in that cycle. Opcode 11h leaves `busy_n` high. At most one pulse is high in any cycle.
- R8: Opcode 07h raises `pulse_sleep` and drives `busy_n` low only when its first parameter is A5h. Any other parameter value has no effect.
- R9: While `busy_n`=0, every byte is ignored. This includes a byte presented in the same cycle as `act_done`. After `act_done`=1, `busy_n` returns to 1 in the next cycle, and `busy_n` never rises without `act_done`.
- R10: Opcode 71h snapshots the status byte, which is then presented on `rd_byte`. The bit layout is: bit 7 = 0, bit 6 = `flag_partial`, bit 5 = `flag_i2c_err`, bit 4 = `flag_i2c_idle`, bit 3 = `flag_data`, bit 2 = power-up state, bit 1 = power-down state, bit 0 = `busy_n`. Opcode 04h sets the power-up state and clears the power-down state. Opcode 02h does the reverse. After reset the power-down state is 1.
- R11: Opcode 70h presents the parameter `REV_ID` (default 01h) on `rd_byte`. Any opcode other than 70h and 71h presents 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_is_param | input | 1 | 1 = parameter byte, 0 = opcode byte |
| in_byte | input | 8 | Received byte |
| act_done | input | 1 | Downstream action finished |
| flag_partial | input | 1 | Partial-window flag, reported in status |
| flag_i2c_err | input | 1 | Sensor bus error, reported in status |
| flag_i2c_idle | input | 1 | Sensor bus not busy, reported in status |
| flag_data | input | 1 | Data flag, reported in status |
| busy_n | output | 1 | Low while an action runs |
| pulse_pwr_on | output | 1 | Power-up action pulse |
| pulse_pwr_off | output | 1 | Power-down action pulse |
| pulse_data_stop | output | 1 | Data-stop pulse |
| pulse_refresh | output | 1 | Refresh action pulse |
| pulse_sleep | output | 1 | Deep-sleep action pulse |
| cfg_panel | output | 8 | Panel configuration byte |
| cfg_boost_a | output | 8 | Booster phase A |
| cfg_boost_b | output | 8 | Booster phase B |
| cfg_boost_c | output | 6 | Booster phase C |
| cfg_hres | output | 9 | Horizontal resolution |
| cfg_vres | output | 9 | Vertical resolution |
| rd_byte | output | 8 | Read-back byte for the last opcode |

## Verification
Two events can land in the same cycle: completion (`act_done`) and a new host byte arriving while the block is still busy. The bench provokes this by presenting a power-down opcode together with `act_done`. The expected result is that `busy_n` is high in the next cycle and no power-down pulse appears, which shows that busy gating was based on the state before completion. A second pairing is the status snapshot immediately after an action completes. This checks that the power state bits and the busy bit in the read-back byte both reflect the finished action.

// File: rtl/cmdbank_pkg.sv
package cmdbank_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;

  localparam logic [7:0] OP_PANEL  = 8'h00;
  localparam logic [7:0] OP_PWROFF = 8'h02;
  localparam logic [7:0] OP_PWRON  = 8'h04;
  localparam logic [7:0] OP_BOOST  = 8'h06;
  localparam logic [7:0] OP_SLEEP  = 8'h07;
  localparam logic [7:0] OP_DSTOP  = 8'h11;
  localparam logic [7:0] OP_REFR   = 8'h12;
  localparam logic [7:0] OP_RES    = 8'h61;
  localparam logic [7:0] OP_REV    = 8'h70;
  localparam logic [7:0] OP_STAT   = 8'h71;

  localparam logic [7:0] SLEEP_KEY = 8'hA5;

  localparam logic [7:0] DEF_PANEL   = 8'h07;
  localparam logic [7:0] DEF_BOOST_A = 8'h03;
  localparam logic [7:0] DEF_BOOST_B = 8'h00;
  localparam logic [5:0] DEF_BOOST_C = 6'h26;
  localparam logic [7:0] DEF_STATUS  = 8'h02;

  typedef struct packed {
    logic partial;
    logic i2c_err;
    logic i2c_idle;
    logic data;
    logic pwr_on;
    logic pwr_off;
    logic busy_n;
  } status_t;

  // number of parameter bytes an opcode accepts
  function automatic logic [IDX_W-1:0] param_count(input logic [7:0] op);
    case (op)
      OP_PANEL: param_count = 3'd1;
      OP_BOOST: param_count = 3'd3;
      OP_SLEEP: param_count = 3'd1;
      OP_RES:   param_count = 3'd4;
      default:  param_count = 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input status_t s);
    pack_status = {1'b0, s.partial, s.i2c_err, s.i2c_idle, s.data,
                   s.pwr_on, s.pwr_off, s.busy_n};
  endfunction

  function automatic logic [8:0] merge_hi(input logic [8:0] cur, input logic [7:0] b);
    merge_hi = {b[0], cur[7:0]};
  endfunction

  function automatic logic [8:0] merge_lo_even(input logic [8:0] cur, input logic [7:0] b);
    merge_lo_even = {cur[8], b[7:1], 1'b0};
  endfunction

  function automatic logic [8:0] merge_lo(input logic [8:0] cur, input logic [7:0] b);
    merge_lo = {cur[8], b};
  endfunction
endpackage

// File: rtl/cmdbank_seq.sv
module cmdbank_seq
  import cmdbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is_param,
  input  logic [7:0]        byte_in,
  output logic [7:0]        cur_op,
  output logic [IDX_W-1:0]  prm_idx,
  output logic              prm_wr,
  output logic              cmd_evt
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  assign cmd_evt = accept && !is_param;
  assign prm_wr  = accept && is_param && (prm_idx < param_count(cur_op));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_op  <= OP_PANEL;
      prm_idx <= '0;
    end else if (cmd_evt) begin
      cur_op  <= byte_in;
      prm_idx <= '0;
    end else if (accept && is_param && prm_idx != IDX_MAX) begin
      prm_idx <= prm_idx + 1'b1;
    end
  end
endmodule

// File: rtl/cmdbank_regs.sv
module cmdbank_regs
  import cmdbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prm_wr,
  input  logic [7:0]        cur_op,
  input  logic [IDX_W-1:0]  prm_idx,
  input  logic [7:0]        byte_in,
  output logic [7:0]        cfg_panel,
  output logic [7:0]        cfg_boost_a,
  output logic [7:0]        cfg_boost_b,
  output logic [5:0]        cfg_boost_c,
  output logic [8:0]        cfg_hres,
  output logic [8:0]        cfg_vres
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_panel   <= DEF_PANEL;
      cfg_boost_a <= DEF_BOOST_A;
      cfg_boost_b <= DEF_BOOST_B;
      cfg_boost_c <= DEF_BOOST_C;
      cfg_hres    <= '0;
      cfg_vres    <= '0;
    end else if (prm_wr) begin
      case (cur_op)
        OP_PANEL: cfg_panel <= byte_in;
        OP_BOOST: begin
          case (prm_idx)
            3'd0:    cfg_boost_a <= byte_in;
            3'd1:    cfg_boost_b <= byte_in;
            default: cfg_boost_c <= byte_in[5:0];
          endcase
        end
        OP_RES: begin
          case (prm_idx)
            3'd0:    cfg_hres <= merge_hi(cfg_hres, byte_in);
            3'd1:    cfg_hres <= merge_lo_even(cfg_hres, byte_in);
            3'd2:    cfg_vres <= merge_hi(cfg_vres, byte_in);
            default: cfg_vres <= merge_lo(cfg_vres, byte_in);
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmdbank_ctl.sv
module cmdbank_ctl
  import cmdbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_evt,
  input  logic              prm_wr,
  input  logic [7:0]        cur_op,
  input  logic [IDX_W-1:0]  prm_idx,
  input  logic [7:0]        byte_in,
  input  logic              act_done,
  input  logic              flag_partial,
  input  logic              flag_i2c_err,
  input  logic              flag_i2c_idle,
  input  logic              flag_data,
  output logic              busy_n,
  output logic              pulse_pwr_on,
  output logic              pulse_pwr_off,
  output logic              pulse_data_stop,
  output logic              pulse_refresh,
  output logic              pulse_sleep,
  output logic [7:0]        status_q
);
  logic go_on, go_off, go_stop, go_refr, go_sleep, go_busy;
  logic pwr_on_q, pwr_off_q;
  status_t live;

  assign go_on    = cmd_evt && byte_in == OP_PWRON;
  assign go_off   = cmd_evt && byte_in == OP_PWROFF;
  assign go_stop  = cmd_evt && byte_in == OP_DSTOP;
  assign go_refr  = cmd_evt && byte_in == OP_REFR;
  assign go_sleep = prm_wr && cur_op == OP_SLEEP && prm_idx == '0 && byte_in == SLEEP_KEY;
  assign go_busy  = go_on || go_off || go_refr || go_sleep;

  always_comb begin
    live.partial  = flag_partial;
    live.i2c_err  = flag_i2c_err;
    live.i2c_idle = flag_i2c_idle;
    live.data     = flag_data;
    live.pwr_on   = pwr_on_q;
    live.pwr_off  = pwr_off_q;
    live.busy_n   = busy_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_n          <= 1'b1;
      pulse_pwr_on    <= 1'b0;
      pulse_pwr_off   <= 1'b0;
      pulse_data_stop <= 1'b0;
      pulse_refresh   <= 1'b0;
      pulse_sleep     <= 1'b0;
      pwr_on_q        <= 1'b0;
      pwr_off_q       <= 1'b1;
      status_q        <= DEF_STATUS;
    end else begin
      pulse_pwr_on    <= go_on;
      pulse_pwr_off   <= go_off;
      pulse_data_stop <= go_stop;
      pulse_refresh   <= go_refr;
      pulse_sleep     <= go_sleep;
      if (!busy_n && act_done) busy_n <= 1'b1;
      else if (go_busy)        busy_n <= 1'b0;
      if (go_on) begin
        pwr_on_q  <= 1'b1;
        pwr_off_q <= 1'b0;
      end else if (go_off) begin
        pwr_on_q  <= 1'b0;
        pwr_off_q <= 1'b1;
      end
      if (cmd_evt && byte_in == OP_STAT) status_q <= pack_status(live);
    end
  end
endmodule

// File: rtl/cmdbank_top.sv
module cmdbank_top
  import cmdbank_pkg::*;
#(
  parameter logic [7:0] REV_ID = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_is_param,
  input  logic [7:0] in_byte,
  input  logic       act_done,
  input  logic       flag_partial,
  input  logic       flag_i2c_err,
  input  logic       flag_i2c_idle,
  input  logic       flag_data,
  output logic       busy_n,
  output logic       pulse_pwr_on,
  output logic       pulse_pwr_off,
  output logic       pulse_data_stop,
  output logic       pulse_refresh,
  output logic       pulse_sleep,
  output logic [7:0] cfg_panel,
  output logic [7:0] cfg_boost_a,
  output logic [7:0] cfg_boost_b,
  output logic [5:0] cfg_boost_c,
  output logic [8:0] cfg_hres,
  output logic [8:0] cfg_vres,
  output logic [7:0] rd_byte
);
  logic             accept;
  logic [7:0]       cur_op;
  logic [IDX_W-1:0] prm_idx;
  logic             prm_wr;
  logic             cmd_evt;
  logic [7:0]       status_q;

  // host bytes count only while idle
  assign accept = in_valid && busy_n;

  cmdbank_seq seq_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .is_param(in_is_param),
    .byte_in(in_byte), .cur_op(cur_op), .prm_idx(prm_idx),
    .prm_wr(prm_wr), .cmd_evt(cmd_evt)
  );

  cmdbank_regs regs_i (
    .clk(clk), .rst_n(rst_n), .prm_wr(prm_wr), .cur_op(cur_op),
    .prm_idx(prm_idx), .byte_in(in_byte), .cfg_panel(cfg_panel),
    .cfg_boost_a(cfg_boost_a), .cfg_boost_b(cfg_boost_b),
    .cfg_boost_c(cfg_boost_c), .cfg_hres(cfg_hres), .cfg_vres(cfg_vres)
  );

  cmdbank_ctl ctl_i (
    .clk(clk), .rst_n(rst_n), .cmd_evt(cmd_evt), .prm_wr(prm_wr),
    .cur_op(cur_op), .prm_idx(prm_idx), .byte_in(in_byte),
    .act_done(act_done), .flag_partial(flag_partial),
    .flag_i2c_err(flag_i2c_err), .flag_i2c_idle(flag_i2c_idle),
    .flag_data(flag_data), .busy_n(busy_n), .pulse_pwr_on(pulse_pwr_on),
    .pulse_pwr_off(pulse_pwr_off), .pulse_data_stop(pulse_data_stop),
    .pulse_refresh(pulse_refresh), .pulse_sleep(pulse_sleep),
    .status_q(status_q)
  );

  always_comb begin
    case (cur_op)
      OP_REV:  rd_byte = REV_ID;
      OP_STAT: rd_byte = status_q;
      default: rd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/cmdbank_chk.sv
module cmdbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_is_param,
  input logic [7:0] in_byte,
  input logic       act_done,
  input logic       busy_n,
  input logic       pulse_pwr_on,
  input logic       pulse_pwr_off,
  input logic       pulse_data_stop,
  input logic       pulse_refresh,
  input logic       pulse_sleep,
  input logic [7:0] cfg_panel,
  input logic [8:0] cfg_hres,
  input logic [8:0] cfg_vres
);
  // R7
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pulse_pwr_on, pulse_pwr_off, pulse_data_stop, pulse_refresh, pulse_sleep}));

  // R7
  action_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_pwr_on || pulse_pwr_off || pulse_refresh || pulse_sleep) |-> !busy_n);

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_data_stop |-> busy_n);

  // R9
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> $past(act_done));

  // R9
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy_n) |-> ($stable(cfg_panel) && $stable(cfg_hres) && $stable(cfg_vres)));

  // R8
  sleep_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_sleep |-> ($past(in_valid) && $past(in_is_param) && $past(in_byte) == 8'hA5));
endmodule

bind cmdbank_top cmdbank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_param(in_is_param),
  .in_byte(in_byte), .act_done(act_done), .busy_n(busy_n),
  .pulse_pwr_on(pulse_pwr_on), .pulse_pwr_off(pulse_pwr_off),
  .pulse_data_stop(pulse_data_stop), .pulse_refresh(pulse_refresh),
  .pulse_sleep(pulse_sleep), .cfg_panel(cfg_panel), .cfg_hres(cfg_hres),
  .cfg_vres(cfg_vres)
);

// File: tb/cmdbank_top_tb_top.sv
module cmdbank_top_tb_top;
  localparam int CLK_P = 10;
  localparam int NVEC = 19;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_is_param = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       act_done = 1'b0;
  logic       flag_partial = 1'b0, flag_i2c_err = 1'b0, flag_i2c_idle = 1'b0, flag_data = 1'b0;
  logic       busy_n, pulse_pwr_on, pulse_pwr_off, pulse_data_stop, pulse_refresh, pulse_sleep;
  logic [7:0] cfg_panel, cfg_boost_a, cfg_boost_b, rd_byte;
  logic [5:0] cfg_boost_c;
  logic [8:0] cfg_hres, cfg_vres;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  cmdbank_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_param(in_is_param),
    .in_byte(in_byte), .act_done(act_done), .flag_partial(flag_partial),
    .flag_i2c_err(flag_i2c_err), .flag_i2c_idle(flag_i2c_idle), .flag_data(flag_data),
    .busy_n(busy_n), .pulse_pwr_on(pulse_pwr_on), .pulse_pwr_off(pulse_pwr_off),
    .pulse_data_stop(pulse_data_stop), .pulse_refresh(pulse_refresh),
    .pulse_sleep(pulse_sleep), .cfg_panel(cfg_panel), .cfg_boost_a(cfg_boost_a),
    .cfg_boost_b(cfg_boost_b), .cfg_boost_c(cfg_boost_c), .cfg_hres(cfg_hres),
    .cfg_vres(cfg_vres), .rd_byte(rd_byte)
  );

  // {req(4), is_param(1), byte(8), sel(4), expected(16)}
  // sel: 1 panel, 2 boost_a, 3 boost_b, 4 boost_c, 5 hres, 6 vres, 7 rd_byte
  localparam logic [32:0] VEC [0:NVEC-1] = '{
    {4'd2,  1'b0, 8'h00, 4'd1, 16'h0007},
    {4'd2,  1'b1, 8'h8C, 4'd1, 16'h008C},
    {4'd5,  1'b1, 8'hFF, 4'd1, 16'h008C},
    {4'd3,  1'b0, 8'h06, 4'd2, 16'h0003},
    {4'd3,  1'b1, 8'h11, 4'd2, 16'h0011},
    {4'd3,  1'b1, 8'h22, 4'd3, 16'h0022},
    {4'd3,  1'b1, 8'hFF, 4'd4, 16'h003F},
    {4'd5,  1'b1, 8'h77, 4'd4, 16'h003F},
    {4'd4,  1'b0, 8'h61, 4'd5, 16'h0000},
    {4'd4,  1'b1, 8'h01, 4'd5, 16'h0100},
    {4'd4,  1'b1, 8'h2B, 4'd5, 16'h012A},
    {4'd4,  1'b1, 8'h01, 4'd6, 16'h0100},
    {4'd4,  1'b1, 8'h2C, 4'd6, 16'h012C},
    {4'd11, 1'b0, 8'h70, 4'd7, 16'h0001},
    {4'd11, 1'b0, 8'h55, 4'd7, 16'h0000},
    {4'd6,  1'b1, 8'h12, 4'd1, 16'h008C},
    {4'd5,  1'b0, 8'h00, 4'd1, 16'h008C},
    {4'd5,  1'b1, 8'h33, 4'd1, 16'h0033},
    {4'd5,  1'b1, 8'h44, 4'd1, 16'h0033}
  };

  function automatic string tag(input int r);
    case (r)
      1: tag = "R1";   2: tag = "R2";   3: tag = "R3";   4: tag = "R4";
      5: tag = "R5";   6: tag = "R6";   7: tag = "R7";   8: tag = "R8";
      9: tag = "R9";   10: tag = "R10"; 11: tag = "R11";
      default: tag = "R?";
    endcase
  endfunction

  function automatic logic [15:0] pick(input int sel);
    case (sel)
      1: pick = {8'h0, cfg_panel};
      2: pick = {8'h0, cfg_boost_a};
      3: pick = {8'h0, cfg_boost_b};
      4: pick = {10'h0, cfg_boost_c};
      5: pick = {7'h0, cfg_hres};
      6: pick = {7'h0, cfg_vres};
      default: pick = {8'h0, rd_byte};
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one byte per cycle; outputs sampled at the following falling edge
  task automatic send(input logic prm, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_is_param = prm; in_byte = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_action();
    @(negedge clk); act_done = 1'b1;
    @(posedge clk);
    @(negedge clk); act_done = 1'b0;
  endtask

  task automatic check_defaults(input string req);
    chk(req, "panel", {8'h0, cfg_panel}, 16'h0007);
    chk(req, "boost_a", {8'h0, cfg_boost_a}, 16'h0003);
    chk(req, "boost_b", {8'h0, cfg_boost_b}, 16'h0000);
    chk(req, "boost_c", {10'h0, cfg_boost_c}, 16'h0026);
    chk(req, "hres", {7'h0, cfg_hres}, 16'h0000);
    chk(req, "vres", {7'h0, cfg_vres}, 16'h0000);
    chk(req, "busy_n", {15'h0, busy_n}, 16'h0001);
    chk(req, "rd_byte", {8'h0, rd_byte}, 16'h0000);
    chk(req, "pulses", {11'h0, pulse_pwr_on, pulse_pwr_off, pulse_data_stop,
                        pulse_refresh, pulse_sleep}, 16'h0000);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_defaults("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_defaults("R1");

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][28], VEC[i][27:20]);
      chk(tag(int'(VEC[i][32:29])), $sformatf("vec%0d", i), pick(int'(VEC[i][19:16])), VEC[i][15:0]);
    end

    // R7 power up: pulse and busy
    send(1'b0, 8'h04);
    chk("R7", "pwr_on pulse", {15'h0, pulse_pwr_on}, 16'h1);
    chk("R7", "busy after pwr_on", {15'h0, busy_n}, 16'h0);
    @(negedge clk);
    chk("R7", "pwr_on pulse width", {15'h0, pulse_pwr_on}, 16'h0);
    // R9 bytes ignored while busy
    send(1'b0, 8'h00);
    send(1'b1, 8'h99);
    chk("R9", "panel while busy", {8'h0, cfg_panel}, 16'h0033);
    // R9 byte in the same cycle as done is dropped
    @(negedge clk);
    act_done = 1'b1; in_valid = 1'b1; in_is_param = 1'b0; in_byte = 8'h02;
    @(posedge clk);
    @(negedge clk);
    act_done = 1'b0; in_valid = 1'b0;
    chk("R9", "busy released", {15'h0, busy_n}, 16'h1);
    chk("R9", "no pwr_off from dropped byte", {15'h0, pulse_pwr_off}, 16'h0);

    // R10 status after power up
    flag_partial = 1'b1; flag_i2c_idle = 1'b1; flag_data = 1'b1;
    send(1'b0, 8'h71);
    chk("R10", "status on", {8'h0, rd_byte}, 16'h005D);
    flag_partial = 1'b0; flag_i2c_idle = 1'b0; flag_data = 1'b0;

    // R7 data stop keeps busy high
    send(1'b0, 8'h11);
    chk("R7", "data stop pulse", {15'h0, pulse_data_stop}, 16'h1);
    chk("R7", "busy after data stop", {15'h0, busy_n}, 16'h1);

    // R7 refresh
    send(1'b0, 8'h12);
    chk("R7", "refresh pulse", {15'h0, pulse_refresh}, 16'h1);
    chk("R7", "busy after refresh", {15'h0, busy_n}, 16'h0);
    finish_action();

    // R8 wrong key then right key
    send(1'b0, 8'h07);
    send(1'b1, 8'h5A);
    chk("R8", "sleep wrong key", {15'h0, pulse_sleep}, 16'h0);
    chk("R8", "busy wrong key", {15'h0, busy_n}, 16'h1);
    send(1'b0, 8'h07);
    send(1'b1, 8'hA5);
    chk("R8", "sleep right key", {15'h0, pulse_sleep}, 16'h1);
    chk("R8", "busy right key", {15'h0, busy_n}, 16'h0);
    finish_action();

    // R10 status after power down
    send(1'b0, 8'h02);
    chk("R7", "pwr_off pulse", {15'h0, pulse_pwr_off}, 16'h1);
    finish_action();
    send(1'b0, 8'h71);
    chk("R10", "status off", {8'h0, rd_byte}, 16'h0003);

    // R1 reset mid-run restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check_defaults("R1");
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule